// File: doc/BRIEF.md
# Two-Wire EEPROM Slave with Paged Writes

This block is the serial front end of a 512-byte non-volatile store whose cells are modelled by on-chip registers. It oversamples the bus clock and data lines with the system clock, finds start and stop conditions, and answers as a bus slave through an open-drain data enable. The slave byte selects either the byte array or a separate register space. Register-space accesses are passed out on a narrow port and decoded by a neighbouring block.

Array writes are collected in a 16-byte page buffer. They reach the array only after a valid stop and a modelled self-timed write cycle. The master may poll for the end of that cycle, because the slave does not acknowledge during it. Reads can start at the current address, at a random address after a dummy write, or run on sequentially.

The register-space port has no back-pressure. `reg_we` is a one-cycle strobe that is always accepted, and `reg_rdata` must hold the value for `reg_addr` while a register read byte is being shifted out. The bus carries no ready signal: the slave never stretches the clock.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: The slave byte is decoded as bits [7:4] type, bits [3:2] which must be 00, bit [1] the high address bit, and bit [0] read (1) or write (0). Type 1010 selects the array and type 1011 selects the register space. Any other slave byte is not acknowledged, and the slave keeps SDA released until the next start.
- R2: A byte write takes the slave byte, then the low address byte, then one data byte. After the following stop and the write cycle, the byte can be read back from that address.
- R3: During a page write only address bits [3:0] advance after each accepted byte. They wrap from 15 to 0 within the same 16-byte page, so bytes beyond the 16th overwrite earlier ones. Bytes in other pages are untouched.
- R4: A stop that arrives after fewer than eight bits of a data byte, or during its acknowledge, abandons the write. The array keeps its contents and no write cycle starts.
- R5: A committed write keeps the slave busy for WR_CYCLES clock cycles after the stop. While busy it acknowledges no slave byte and never drives SDA.
- R6: When `bp_i` is 1, data bytes addressed to 100h-1FFh are not acknowledged and are not written. When `wp_i` is 1, no array or register write is acknowledged or performed.
- R7: While `wel_i` is 0, array data bytes are not acknowledged and are not written.
- R8: A read returns the byte at the address counter, and the counter advances by one after each byte across the whole 9-bit space, wrapping from 1FFh to 000h. The slave stops driving once the master does not acknowledge a byte.
- R9: A random read is a write slave byte plus an address byte, then a repeated start with a read slave byte. An address byte ended by a stop loads the counter only, and starts no write cycle.
- R10: In the register space, the first data byte of a write pulses `reg_we` for one cycle with `reg_addr` and `reg_wdata`, and is acknowledged. Later data bytes in the same transfer are not acknowledged and produce no strobe. A register read returns `reg_rdata`.
- R11: After reset SDA is released, and the slave is idle and not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| wp_i | input | 1 | Write-protect pin, 1 blocks every write |
| wel_i | input | 1 | Write-enable latch from the register block |
| bp_i | input | 1 | Block-protect bit, 1 locks the upper half |
| reg_addr | output | 8 | Register-space address from the last address byte |
| reg_wdata | output | 8 | Register-space write data |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Register-space read data for `reg_addr` |

## Verification
A bus edge passes through two synchronizer stages and one edge register, and the registered SDA enable then changes, so the slave's acknowledge or data bit is visible three to four clock cycles after the SCL fall that calls for it. The bench holds every SCL phase for six cycles and samples SDA in the middle of the high phase, which keeps it clear of that latency. A committed write holds off acknowledges for WR_CYCLES cycles after the stop is seen. The bench therefore checks the write cycle by polling: the first poll must go unacknowledged and a later one must be acknowledged. When no write cycle should have started, the first poll must be acknowledged.

// File: rtl/eeprom_slave_pkg.sv
package eeprom_slave_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_ADDR, ST_WR, ST_RD, ST_NONE
  } bus_st_e;
  localparam logic [3:0] TYPE_ARRAY = 4'b1010;
  localparam logic [3:0] TYPE_REGS  = 4'b1011;
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_s, sda_s;
  logic scl, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_s <= {scl_s[SYNC_STAGES-2:0], scl_i};
      sda_s <= {sda_s[SYNC_STAGES-2:0], sda_i};
      scl_d <= scl;
      sda_d <= sda;
    end
  end

  assign scl       = scl_s[SYNC_STAGES-1];
  assign sda       = sda_s[SYNC_STAGES-1];
  assign scl_rise  = scl & ~scl_d;
  assign scl_fall  = ~scl & scl_d;
  assign start_det = scl & scl_d & sda_d & ~sda;
  assign stop_det  = scl & scl_d & ~sda_d & sda;
endmodule

// File: rtl/eeprom_page_store.sv
module eeprom_page_store #(
  parameter int ADDR_W    = 9,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 250000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     buf_clear,
  input  logic                     buf_we,
  input  logic [PAGE_W-1:0]        buf_idx,
  input  logic [ADDR_W-PAGE_W-1:0] buf_page,
  input  logic [7:0]               buf_data,
  input  logic                     commit,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [7:0]               rd_data,
  output logic                     busy
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int TMR_W      = $clog2(WR_CYCLES + 1);

  logic [7:0]                mem [DEPTH];
  logic [7:0]                pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]     pvalid_q;
  logic [ADDR_W-PAGE_W-1:0]  page_q;
  logic [TMR_W-1:0]          timer_q;
  logic                      busy_q;
  logic                      expire;

  assign expire = busy_q && (timer_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      timer_q  <= '0;
      pvalid_q <= '0;
      page_q   <= '0;
    end else if (busy_q) begin
      if (expire) begin
        busy_q   <= 1'b0;
        pvalid_q <= '0;
      end else begin
        timer_q <= timer_q - 1'b1;
      end
    end else begin
      if (commit) begin
        busy_q  <= 1'b1;
        timer_q <= TMR_W'(WR_CYCLES - 1);
      end else if (buf_clear) begin
        pvalid_q <= '0;
      end
      if (buf_we) begin
        pvalid_q[buf_idx] <= 1'b1;
        page_q            <= buf_page;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we && !busy_q) pbuf[buf_idx] <= buf_data;
    if (expire) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (pvalid_q[i]) mem[{page_q, PAGE_W'(i)}] <= pbuf[i];
      end
    end
  end

  assign rd_data = mem[rd_addr];
  assign busy    = busy_q;

  // R5
  expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && timer_q == '0) |=> !busy_q);
  // R5
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> !busy_q);
endmodule

// File: rtl/eeprom_bus_fsm.sv
module eeprom_bus_fsm
  import eeprom_slave_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sda,
  input  logic                     scl_rise,
  input  logic                     scl_fall,
  input  logic                     start_det,
  input  logic                     stop_det,
  input  logic                     wp_i,
  input  logic                     wel_i,
  input  logic                     bp_i,
  input  logic                     busy_i,
  input  logic [7:0]               rd_data,
  input  logic [7:0]               reg_rdata,
  output logic                     sda_oe,
  output logic [ADDR_W-1:0]        rd_addr,
  output logic                     buf_we,
  output logic [PAGE_W-1:0]        buf_idx,
  output logic [ADDR_W-PAGE_W-1:0] buf_page,
  output logic [7:0]               buf_data,
  output logic                     buf_clear,
  output logic                     commit,
  output logic [7:0]               reg_addr,
  output logic [7:0]               reg_wdata,
  output logic                     reg_we
);
  bus_st_e st_q;
  logic [3:0] cnt_q;
  logic [7:0] rx_q;
  logic [6:0] tx_q;
  logic [ADDR_W-1:0] addr_q;
  logic sda_oe_q, mack_q, is_reg_q, a8_q, rw_q, first_q, wr_pend_q;
  logic [7:0] rd_src;
  logic dev_ok, mem_ok;

  assign rd_src = is_reg_q ? reg_rdata : rd_data;
  assign dev_ok = (rx_q[3:2] == 2'b00) && !busy_i &&
                  ((rx_q[7:4] == TYPE_ARRAY) || (rx_q[7:4] == TYPE_REGS));
  assign mem_ok = wel_i && !wp_i && !(bp_i && addr_q[ADDR_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  cnt_q <= '0;  rx_q <= '0;  tx_q <= '0;
      addr_q <= '0;  sda_oe_q <= 1'b0;  mack_q <= 1'b0;  is_reg_q <= 1'b0;
      a8_q <= 1'b0;  rw_q <= 1'b0;  first_q <= 1'b0;  wr_pend_q <= 1'b0;
      buf_we <= 1'b0;  buf_idx <= '0;  buf_page <= '0;  buf_data <= '0;
      buf_clear <= 1'b0;  commit <= 1'b0;
      reg_addr <= '0;  reg_wdata <= '0;  reg_we <= 1'b0;
    end else begin
      buf_we <= 1'b0;  buf_clear <= 1'b0;  commit <= 1'b0;  reg_we <= 1'b0;
      if (start_det) begin
        st_q <= ST_DEV;  cnt_q <= '0;  sda_oe_q <= 1'b0;
        wr_pend_q <= 1'b0;  buf_clear <= 1'b1;
      end else if (stop_det) begin
        if (st_q == ST_WR && wr_pend_q && !is_reg_q && cnt_q <= 4'd1) commit <= 1'b1;
        st_q <= ST_IDLE;  sda_oe_q <= 1'b0;  wr_pend_q <= 1'b0;
      end else if (st_q != ST_IDLE && st_q != ST_NONE) begin
        if (scl_rise) begin
          if (cnt_q < 4'd8) rx_q <= {rx_q[6:0], sda};
          if (cnt_q == 4'd8) mack_q <= !sda;
          if (cnt_q < 4'd9) cnt_q <= cnt_q + 1'b1;
        end else if (scl_fall) begin
          if (st_q == ST_RD) begin
            if (cnt_q >= 4'd1 && cnt_q <= 4'd7) begin
              sda_oe_q <= !tx_q[6];
              tx_q     <= {tx_q[5:0], 1'b0};
            end else if (cnt_q == 4'd8) begin
              sda_oe_q <= 1'b0;
              if (!is_reg_q) addr_q <= addr_q + 1'b1;
            end else if (cnt_q == 4'd9) begin
              if (mack_q) begin
                tx_q <= rd_src[6:0];  sda_oe_q <= !rd_src[7];  cnt_q <= '0;
              end else begin
                st_q <= ST_NONE;
              end
            end
          end else if (cnt_q == 4'd8) begin
            case (st_q)
              ST_DEV: begin
                if (dev_ok) begin
                  sda_oe_q <= 1'b1;  is_reg_q <= (rx_q[7:4] == TYPE_REGS);
                  a8_q <= rx_q[1];  rw_q <= rx_q[0];
                end else begin
                  st_q <= ST_NONE;
                end
              end
              ST_ADDR: begin
                sda_oe_q <= 1'b1;
                if (is_reg_q) reg_addr <= rx_q;
                else addr_q <= ADDR_W'({a8_q, rx_q});
              end
              ST_WR: begin
                if (is_reg_q) begin
                  if (first_q && !wp_i) begin
                    reg_we <= 1'b1;  reg_wdata <= rx_q;  sda_oe_q <= 1'b1;
                  end
                  first_q <= 1'b0;
                end else if (mem_ok) begin
                  buf_we   <= 1'b1;  buf_data <= rx_q;
                  buf_idx  <= addr_q[PAGE_W-1:0];
                  buf_page <= addr_q[ADDR_W-1:PAGE_W];
                  addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + 1'b1;
                  wr_pend_q <= 1'b1;  sda_oe_q <= 1'b1;
                end
              end
              default: ;
            endcase
          end else if (cnt_q == 4'd9) begin
            sda_oe_q <= 1'b0;  cnt_q <= '0;
            if (st_q == ST_DEV) begin
              if (rw_q) begin
                st_q <= ST_RD;  tx_q <= rd_src[6:0];  sda_oe_q <= !rd_src[7];
              end else begin
                st_q <= ST_ADDR;
              end
            end else if (st_q == ST_ADDR) begin
              st_q <= ST_WR;  first_q <= 1'b1;
            end
          end
        end
      end
    end
  end

  assign sda_oe  = sda_oe_q;
  assign rd_addr = addr_q;

  // R5
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> !sda_oe_q);
  // R1
  none_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_NONE) |-> !sda_oe_q);
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave #(
  parameter int ADDR_W      = 9,
  parameter int PAGE_W      = 4,
  parameter int WR_CYCLES   = 250000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       wp_i,
  input  logic       wel_i,
  input  logic       bp_i,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata
);
  localparam int PG_W = ADDR_W - PAGE_W;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, buf_we, buf_clear, commit;
  logic [PAGE_W-1:0] buf_idx;
  logic [PG_W-1:0]   buf_page;
  logic [7:0]        buf_data, rd_data;
  logic [ADDR_W-1:0] rd_addr;

  i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eeprom_bus_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .wp_i(wp_i), .wel_i(wel_i), .bp_i(bp_i), .busy_i(busy),
    .rd_data(rd_data), .reg_rdata(reg_rdata), .sda_oe(sda_oe),
    .rd_addr(rd_addr), .buf_we(buf_we), .buf_idx(buf_idx),
    .buf_page(buf_page), .buf_data(buf_data), .buf_clear(buf_clear),
    .commit(commit), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we)
  );

  eeprom_page_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n), .buf_clear(buf_clear), .buf_we(buf_we),
    .buf_idx(buf_idx), .buf_page(buf_page), .buf_data(buf_data),
    .commit(commit), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  // R6
  wp_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we || reg_we) |-> !$past(wp_i));
endmodule

// File: tb/eeprom_i2c_slave_bench.sv
module eeprom_i2c_slave_bench;
  localparam int Q = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, msda = 1'b1;
  logic wp = 1'b0, wel = 1'b1, bp = 1'b0;
  logic [7:0] reg_rdata = 8'hC5;
  logic sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata;
  wire sda_line = msda & ~sda_oe;

  int tests = 0, fails = 0, reg_cnt = 0;
  logic [7:0] cap_a, cap_d;
  logic [7:0] wdat [32];
  logic [7:0] rdat [32];
  bit done = 1'b0;

  always #10 clk = ~clk;

  eeprom_i2c_slave #(.WR_CYCLES(400)) u_eeprom_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .wp_i(wp), .wel_i(wel), .bp_i(bp), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) if (reg_we) begin
    reg_cnt <= reg_cnt + 1;  cap_a <= reg_addr;  cap_d <= reg_wdata;
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start;
    msda = 1'b1; tick(Q); scl = 1'b1; tick(Q); msda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    msda = 1'b0; tick(Q); scl = 1'b1; tick(Q); msda = 1'b1; tick(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      msda = b[i]; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    msda = 1'b1; tick(Q); scl = 1'b1; tick(Q/2); ack = !sda_line;
    tick(Q - Q/2); scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic last, output logic [7:0] b);
    msda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl = 1'b1; tick(Q/2); b[i] = sda_line; tick(Q - Q/2); scl = 1'b0;
    end
    msda = last; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic mem_write(input logic [8:0] a, input int n, output int acks);
    logic k;
    bus_start;
    send_byte({4'hA, 2'b00, a[8], 1'b0}, k);
    send_byte(a[7:0], k);
    acks = 0;
    for (int i = 0; i < n; i++) begin send_byte(wdat[i], k); acks += int'(k); end
    bus_stop;
  endtask

  task automatic wait_ready(output int polls);
    logic k = 1'b0;
    polls = 0;
    while (!k && polls < 20) begin
      bus_start; send_byte(8'hA0, k); bus_stop; polls++;
    end
  endtask

  task automatic mem_read(input logic [8:0] a, input int n);
    logic k;
    bus_start;
    send_byte({4'hA, 2'b00, a[8], 1'b0}, k);
    send_byte(a[7:0], k);
    bus_start;
    send_byte(8'hA1, k);
    for (int i = 0; i < n; i++) recv_byte(i == n - 1, rdat[i]);
    bus_stop;
  endtask

  task automatic cur_read(output logic [7:0] b);
    logic k;
    bus_start; send_byte(8'hA1, k); recv_byte(1'b1, b); bus_stop;
  endtask

  task automatic t_reset;
    check(sda_oe == 1'b0, "R11 sda released after reset", sda_oe, 0);
    check(reg_cnt == 0, "R11 no register strobe after reset", reg_cnt, 0);
  endtask

  task automatic t_bad_type;
    logic k;
    bus_start; send_byte(8'h90, k);
    check(!k, "R1 wrong type not acknowledged", k, 0);
    send_byte(8'h12, k);
    check(!k, "R1 silent until next start", k, 0);
    bus_stop;
    bus_start; send_byte(8'hA4, k);
    check(!k, "R1 nonzero bits 3:2 not acknowledged", k, 0);
    bus_stop;
  endtask

  task automatic t_byte_write;
    int acks, polls;
    wdat[0] = 8'h3C; mem_write(9'h012, 1, acks); wait_ready(polls);
    check(acks == 1, "R2 data byte acknowledged", acks, 1);
    mem_read(9'h012, 1);
    check(rdat[0] == 8'h3C, "R2 byte write read back", rdat[0], 8'h3C);
  endtask

  task automatic t_page_wrap;
    int acks, polls;
    logic [7:0] exp [16];
    logic [7:0] b;
    wdat[0] = 8'hEE; mem_write(9'h030, 1, acks); wait_ready(polls);
    for (int k = 0; k < 20; k++) begin
      wdat[k] = 8'h40 + 8'(k);
      exp[(10 + k) % 16] = 8'h40 + 8'(k);
    end
    mem_write(9'h02A, 20, acks); wait_ready(polls);
    check(acks == 20, "R3 all page bytes acknowledged", acks, 20);
    cur_read(b);
    check(b == 8'h44, "R8 current address after wrapped page", b, 8'h44);
    mem_read(9'h020, 17);
    for (int o = 0; o < 16; o++)
      check(rdat[o] == exp[o], "R3 page wrap content", rdat[o], exp[o]);
    check(rdat[16] == 8'hEE, "R3 next page untouched", rdat[16], 8'hEE);
  endtask

  task automatic t_abort;
    int acks, polls;
    logic k;
    wdat[0] = 8'h11; mem_write(9'h050, 1, acks); wait_ready(polls);
    bus_start; send_byte(8'hA0, k); send_byte(8'h50, k); send_byte(8'h99, k);
    send_bits(8'h5A, 4); bus_stop;
    wait_ready(polls);
    check(polls == 1, "R4 no write cycle after mid-byte stop", polls, 1);
    mem_read(9'h050, 1);
    check(rdat[0] == 8'h11, "R4 array unchanged after abort", rdat[0], 8'h11);
  endtask

  task automatic t_busy;
    int acks, polls;
    wdat[0] = 8'h5D; mem_write(9'h0A0, 1, acks); wait_ready(polls);
    check(polls > 1, "R5 slave byte ignored during write cycle", polls, 2);
    check(polls < 20, "R5 acknowledged after write cycle", polls, 3);
  endtask

  task automatic t_protect;
    int acks, polls;
    logic k;
    wdat[0] = 8'h77; mem_write(9'h150, 1, acks); wait_ready(polls);
    bp = 1'b1;
    wdat[0] = 8'h88; mem_write(9'h150, 1, acks); wait_ready(polls);
    check(acks == 0, "R6 upper half data not acknowledged", acks, 0);
    check(polls == 1, "R6 no write cycle for locked half", polls, 1);
    mem_read(9'h150, 1);
    check(rdat[0] == 8'h77, "R6 upper half unchanged", rdat[0], 8'h77);
    wdat[0] = 8'h33; mem_write(9'h0F0, 1, acks); wait_ready(polls);
    mem_read(9'h0F0, 1);
    check(rdat[0] == 8'h33, "R6 lower half writable under lock", rdat[0], 8'h33);
    bp = 1'b0; wp = 1'b1;
    wdat[0] = 8'h99; mem_write(9'h012, 1, acks); wait_ready(polls);
    check(acks == 0, "R6 write-protect pin blocks acknowledge", acks, 0);
    mem_read(9'h012, 1);
    check(rdat[0] == 8'h3C, "R6 write-protect pin keeps data", rdat[0], 8'h3C);
    bus_start; send_byte(8'hB0, k); send_byte(8'h21, k); send_byte(8'h44, k);
    check(!k, "R6 register write blocked by pin", k, 0);
    bus_stop;
    check(reg_cnt == 0, "R6 no register strobe under pin", reg_cnt, 0);
    wp = 1'b0;
  endtask

  task automatic t_wel;
    int acks, polls;
    wel = 1'b0;
    wdat[0] = 8'h55; mem_write(9'h012, 1, acks); wait_ready(polls);
    check(acks == 0, "R7 data not acknowledged with latch clear", acks, 0);
    mem_read(9'h012, 1);
    check(rdat[0] == 8'h3C, "R7 array unchanged with latch clear", rdat[0], 8'h3C);
    wel = 1'b1;
  endtask

  task automatic t_seq_wrap;
    int acks, polls;
    wdat[0] = 8'hA1; wdat[1] = 8'hA2; mem_write(9'h1FE, 2, acks); wait_ready(polls);
    wdat[0] = 8'hA3; wdat[1] = 8'hA4; mem_write(9'h000, 2, acks); wait_ready(polls);
    mem_read(9'h1FE, 4);
    check(rdat[0] == 8'hA1, "R8 sequential read 1FE", rdat[0], 8'hA1);
    check(rdat[1] == 8'hA2, "R8 sequential read 1FF", rdat[1], 8'hA2);
    check(rdat[2] == 8'hA3, "R8 rollover to 000", rdat[2], 8'hA3);
    check(rdat[3] == 8'hA4, "R8 sequential read 001", rdat[3], 8'hA4);
    check(sda_oe == 1'b0, "R8 released after master nack", sda_oe, 0);
  endtask

  task automatic t_addr_only;
    int acks, polls;
    logic k;
    logic [7:0] b;
    wdat[0] = 8'h6B; mem_write(9'h1A3, 1, acks); wait_ready(polls);
    bus_start; send_byte(8'hA2, k); send_byte(8'hA3, k); bus_stop;
    wait_ready(polls);
    check(polls == 1, "R9 address-only write starts no cycle", polls, 1);
    cur_read(b);
    check(b == 8'h6B, "R9 counter loaded by address-only write", b, 8'h6B);
  endtask

  task automatic t_regs;
    logic k;
    logic [7:0] b;
    bus_start; send_byte(8'hB0, k);
    check(k, "R10 register type acknowledged", k, 1);
    send_byte(8'h3C, k); send_byte(8'h5A, k);
    check(k, "R10 first register byte acknowledged", k, 1);
    send_byte(8'h66, k);
    check(!k, "R10 second register byte refused", k, 0);
    bus_stop;
    check(reg_cnt == 1, "R10 one register strobe", reg_cnt, 1);
    check(cap_a == 8'h3C && cap_d == 8'h5A, "R10 register address and data",
          {cap_a, cap_d}, 16'h3C5A);
    bus_start; send_byte(8'hB0, k); send_byte(8'h3C, k);
    bus_start; send_byte(8'hB1, k); recv_byte(1'b1, b); bus_stop;
    check(b == 8'hC5, "R10 register read data", b, 8'hC5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tick(5); rst_n = 1'b1; tick(5);
    t_reset;
    t_bad_type;
    t_byte_write;
    t_page_wrap;
    t_abort;
    t_busy;
    t_protect;
    t_wel;
    t_seq_wrap;
    t_addr_only;
    t_regs;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule